// File: doc/BRIEF.md
# Register-Mask Block Transfer Sequencer

This block moves a group of processor registers to or from memory in one operation. A 16-bit mask selects which registers take part. The eight data registers occupy register-file indices 0 to 7, and the eight address registers occupy indices 8 to 15. A single start pulse captures the whole configuration:

- the mask;
- the direction;
- the operand size (word or long);
- the address mode;
- the index of the base address register;
- the starting address, which is already computed by the caller.

The sequencer then walks the mask one bit per step. For every set bit it issues one memory access through a request/acknowledge port and moves the running address. It reads or writes the register file through a single shared port.

Three address modes exist: control (the address only advances), post-increment (reads only) and pre-decrement (writes only, with the register order reversed). In post-increment and pre-decrement mode, the final address goes back into the base address register. When the operation ends, the block reports its execution cost in cycles and raises a one-cycle done pulse.

Top module: `mmove_seq`

## Requirements
- R1: The mask is scanned from bit 0 upward and clear bits are skipped. Outside pre-decrement mode, bit n selects register-file index n.
- R2: In pre-decrement mode (mode = 2), bit n selects register-file index 15-n.
- R3: In control (mode = 0) and post-increment (mode = 1) modes, the first access is at the start address. The address then rises by 2 (isLong = 0) or 4 (isLong = 1) after each access.
- R4: In pre-decrement mode, the address drops by the step before each access, so the first access is at start address minus step.
- R5: In modes 1 and 2, after the last transfer the final address is written to register-file index 8 + baseReg. In mode 0 no write-back occurs.
- R6: At done, `cost` equals 8 (toMem = 1) or 12 (toMem = 0) plus 4 per word or 8 per long transferred.
- R7: A word read is sign-extended from memRdata[15:0] before it is stored. A word write places the register's low 16 bits on memWdata[15:0] with the upper bits zero. A long uses all 32 bits.
- R8: A start is ignored (busy stays low, with no access and no register write) for any of these: mode 3, pre-decrement with toMem = 0, or post-increment with toMem = 1.
- R9: An all-zero mask produces no memory access. The write-back of R5 still happens, followed by done.
- R10: memReq stays high with a stable memAddr until memAck is seen.
- R11: done is a single-cycle pulse. A start while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse; captures the configuration below |
| mask | input | 16 | Register selection mask |
| toMem | input | 1 | 1: registers to memory, 0: memory to registers |
| isLong | input | 1 | 1: 32-bit transfers, 0: 16-bit transfers |
| mode | input | 2 | 0 control, 1 post-increment, 2 pre-decrement |
| baseReg | input | 3 | Address register that receives the write-back |
| baseAddr | input | 24 | Starting address |
| memReq | output | 1 | Memory request |
| memWe | output | 1 | Memory write enable |
| memAddr | output | 24 | Memory byte address |
| memWdata | output | 32 | Memory write data |
| memRdata | input | 32 | Memory read data, valid with memAck |
| memAck | input | 1 | Memory acknowledge |
| rfIdx | output | 4 | Register-file index for read and write |
| rfRdata | input | 32 | Combinational register-file read data |
| rfWe | output | 1 | Register-file write enable |
| rfWdata | output | 32 | Register-file write data |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| cost | output | 8 | Execution cost of the last operation in cycles |

## Verification
A wrong running address shows up at the very first request as a memAddr that is off by one step. A wrong mask position or index mapping shows up at done as a register or memory word landing in the wrong place. A miscounted cost or a missing or extra write-back appears in the cycle that done pulses. The sweep covers every legal pairing of mode and direction, both sizes and masks with sparse, dense, edge and empty bit patterns. Each access address is compared in order, so an error is traced to the step where it first occurs.

// File: rtl/mmove_pkg.sv
package mmove_pkg;
  typedef enum logic [1:0] {
    MODE_CTRL = 2'd0,
    MODE_POST = 2'd1,
    MODE_PRE  = 2'd2,
    MODE_BAD  = 2'd3
  } amode_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SCAN, ST_MEM, ST_WB, ST_FIN
  } state_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;    // capture configuration
    logic skip;    // drop a clear mask bit
    logic preStep; // subtract step before access
    logic retire;  // access acknowledged: advance
    logic wbSel;   // register port carries write-back
  } strobe_t;
endpackage

// File: rtl/mmove_ctrl.sv
module mmove_ctrl
  import mmove_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    legal,
  input  logic    maskEmpty,
  input  logic    curBit,
  input  logic    isPre,
  input  logic    needWb,
  input  logic    toMemQ,
  input  logic    memAck,
  output strobe_t stb,
  output logic    memReq,
  output logic    rfWe,
  output logic    busy,
  output logic    done
);
  state_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    stb       = '0;
    memReq    = 1'b0;
    rfWe      = 1'b0;
    done      = 1'b0;
    unique case (state)
      ST_IDLE: if (start && legal) begin
        stb.load  = 1'b1;
        nextState = ST_SCAN;
      end
      ST_SCAN: begin
        if (maskEmpty) begin
          nextState = needWb ? ST_WB : ST_FIN;
        end else if (curBit) begin
          stb.preStep = isPre;
          nextState   = ST_MEM;
        end else begin
          stb.skip = 1'b1;
        end
      end
      ST_MEM: begin
        memReq = 1'b1;
        if (memAck) begin
          stb.retire = 1'b1;
          rfWe       = !toMemQ;
          nextState  = ST_SCAN;
        end
      end
      ST_WB: begin
        stb.wbSel = 1'b1;
        rfWe      = 1'b1;
        nextState = ST_FIN;
      end
      ST_FIN: begin
        done      = 1'b1;
        nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  assign busy = (state != ST_IDLE);
endmodule

// File: rtl/mmove_dp.sv
module mmove_dp
  import mmove_pkg::*;
#(
  parameter int NREG = 16,
  parameter int AW   = 24,
  parameter int DW   = 32,
  localparam int RIW = $clog2(NREG),
  localparam int CW  = $clog2(12 + NREG * 8 + 1)
) (
  input  logic            clk,
  input  logic            rstN,
  input  strobe_t         stb,
  input  logic [NREG-1:0] mask,
  input  logic            toMem,
  input  logic            isLong,
  input  logic [1:0]      mode,
  input  logic [RIW-2:0]  baseReg,
  input  logic [AW-1:0]   baseAddr,
  input  logic [DW-1:0]   memRdata,
  input  logic [DW-1:0]   rfRdata,
  output logic            legal,
  output logic            maskEmpty,
  output logic            curBit,
  output logic            isPre,
  output logic            needWb,
  output logic            toMemQ,
  output logic [AW-1:0]   memAddr,
  output logic [DW-1:0]   memWdata,
  output logic [RIW-1:0]  rfIdx,
  output logic [DW-1:0]   rfWdata,
  output logic [CW-1:0]   cost
);
  logic [NREG-1:0] maskQ;
  logic [RIW-1:0]  posQ;
  logic [AW-1:0]   addrQ;
  logic [CW-1:0]   costQ;
  logic            longQ;
  logic [1:0]      modeQ;
  logic [RIW-2:0]  baseQ;
  logic [AW-1:0]   step;
  logic [RIW-1:0]  regIdx;

  assign legal = (mode != MODE_BAD) && !(mode == MODE_PRE && !toMem)
                 && !(mode == MODE_POST && toMem);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskQ  <= '0;
      posQ   <= '0;
      addrQ  <= '0;
      costQ  <= '0;
      longQ  <= 1'b0;
      modeQ  <= MODE_CTRL;
      baseQ  <= '0;
      toMemQ <= 1'b0;
    end else if (stb.load) begin
      maskQ  <= mask;
      posQ   <= '0;
      addrQ  <= baseAddr;
      costQ  <= toMem ? CW'(8) : CW'(12);
      longQ  <= isLong;
      modeQ  <= mode;
      baseQ  <= baseReg;
      toMemQ <= toMem;
    end else begin
      if (stb.preStep) addrQ <= addrQ - step;
      if (stb.skip || stb.retire) begin
        maskQ <= maskQ >> 1;
        posQ  <= posQ + 1'b1;
      end
      if (stb.retire) begin
        costQ <= costQ + (longQ ? CW'(8) : CW'(4));
        if (!isPre) addrQ <= addrQ + step;
      end
    end
  end

  assign step      = longQ ? AW'(4) : AW'(2);
  assign isPre     = (modeQ == MODE_PRE);
  assign needWb    = (modeQ != MODE_CTRL);
  assign maskEmpty = (maskQ == '0);
  assign curBit    = maskQ[0];
  assign regIdx    = isPre ? RIW'(NREG - 1) - posQ : posQ;
  assign rfIdx     = stb.wbSel ? {1'b1, baseQ} : regIdx;
  assign memAddr   = addrQ;
  assign memWdata  = longQ ? rfRdata : {{(DW-16){1'b0}}, rfRdata[15:0]};
  assign cost      = costQ;

  always_comb begin
    if (stb.wbSel)  rfWdata = {{(DW-AW){1'b0}}, addrQ};
    else if (longQ) rfWdata = memRdata;
    else            rfWdata = {{(DW-16){memRdata[15]}}, memRdata[15:0]};
  end
endmodule

// File: rtl/mmove_seq.sv
module mmove_seq
  import mmove_pkg::*;
#(
  parameter int NREG = 16,
  parameter int AW   = 24,
  parameter int DW   = 32,
  localparam int RIW = $clog2(NREG),
  localparam int CW  = $clog2(12 + NREG * 8 + 1)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            start,
  input  logic [NREG-1:0] mask,
  input  logic            toMem,
  input  logic            isLong,
  input  logic [1:0]      mode,
  input  logic [RIW-2:0]  baseReg,
  input  logic [AW-1:0]   baseAddr,
  output logic            memReq,
  output logic            memWe,
  output logic [AW-1:0]   memAddr,
  output logic [DW-1:0]   memWdata,
  input  logic [DW-1:0]   memRdata,
  input  logic            memAck,
  output logic [RIW-1:0]  rfIdx,
  input  logic [DW-1:0]   rfRdata,
  output logic            rfWe,
  output logic [DW-1:0]   rfWdata,
  output logic            busy,
  output logic            done,
  output logic [CW-1:0]   cost
);
  strobe_t stb;
  logic legal, maskEmpty, curBit, isPre, needWb, toMemQ;

  mmove_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .legal(legal),
    .maskEmpty(maskEmpty), .curBit(curBit), .isPre(isPre),
    .needWb(needWb), .toMemQ(toMemQ), .memAck(memAck), .stb(stb),
    .memReq(memReq), .rfWe(rfWe), .busy(busy), .done(done)
  );

  mmove_dp #(.NREG(NREG), .AW(AW), .DW(DW)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .mask(mask), .toMem(toMem),
    .isLong(isLong), .mode(mode), .baseReg(baseReg), .baseAddr(baseAddr),
    .memRdata(memRdata), .rfRdata(rfRdata), .legal(legal),
    .maskEmpty(maskEmpty), .curBit(curBit), .isPre(isPre), .needWb(needWb),
    .toMemQ(toMemQ), .memAddr(memAddr), .memWdata(memWdata), .rfIdx(rfIdx),
    .rfWdata(rfWdata), .cost(cost)
  );

  assign memWe = memReq && toMemQ;
endmodule

// File: rtl/mmove_chk.sv
module mmove_chk #(
  parameter int AW = 24
) (
  input logic          clk,
  input logic          rstN,
  input logic          memReq,
  input logic          memAck,
  input logic          memWe,
  input logic [AW-1:0] memAddr,
  input logic          rfWe,
  input logic          busy,
  input logic          done
);
  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> memReq);
  p_addr_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> $stable(memAddr));
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !memReq && !rfWe);
  p_write_no_rf_r7: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memWe |-> !rfWe);
  p_done_busy_r11: assert property (@(posedge clk) disable iff (!rstN)
    done |-> busy && !memReq);
endmodule

bind mmove_seq mmove_chk #(.AW(AW)) u_chk (
  .clk(clk), .rstN(rstN), .memReq(memReq), .memAck(memAck), .memWe(memWe),
  .memAddr(memAddr), .rfWe(rfWe), .busy(busy), .done(done)
);

// File: tb/sim_mmove_seq.sv
module sim_mmove_seq;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [15:0] mask = '0;
  logic        toMem = 1'b0, isLong = 1'b0;
  logic [1:0]  mode = '0;
  logic [2:0]  baseReg = '0;
  logic [23:0] baseAddr = '0;
  logic        memReq, memWe, memAck = 1'b0;
  logic [23:0] memAddr;
  logic [31:0] memWdata, memRdata = '0;
  logic [3:0]  rfIdx;
  logic [31:0] rfRdata, rfWdata;
  logic        rfWe, busy, done;
  logic [7:0]  cost;

  int nChk = 0, nFail = 0;
  logic [7:0]  mem [1024];
  logic [7:0]  emem [1024];
  logic [31:0] rf [16];
  logic [31:0] erf [16];
  logic [23:0] logAddr [32];
  int logCnt = 0;
  int rfWrites = 0;

  always #2.5 clk = ~clk;

  mmove_seq u0 (.*);

  assign rfRdata = rf[rfIdx];

  always @(posedge clk) begin
    if (memReq && !memAck) begin
      if (logCnt < 32) logAddr[logCnt] <= memAddr;
      logCnt <= logCnt + 1;
      if (memWe) begin
        if (isLongQ) begin
          mem[memAddr[9:0]]      <= memWdata[31:24];
          mem[memAddr[9:0] + 1]  <= memWdata[23:16];
          mem[memAddr[9:0] + 2]  <= memWdata[15:8];
          mem[memAddr[9:0] + 3]  <= memWdata[7:0];
        end else begin
          if (memWdata[31:16] != 16'h0) begin
            nChk <= nChk + 1; nFail <= nFail + 1;
            $display("FAIL R7 word write upper bits %h exp 0000", memWdata[31:16]);
          end
          mem[memAddr[9:0]]      <= memWdata[15:8];
          mem[memAddr[9:0] + 1]  <= memWdata[7:0];
        end
      end else begin
        memRdata <= isLongQ ?
          {mem[memAddr[9:0]], mem[memAddr[9:0]+1], mem[memAddr[9:0]+2], mem[memAddr[9:0]+3]} :
          {16'hDEAD, mem[memAddr[9:0]], mem[memAddr[9:0]+1]};
      end
      memAck <= 1'b1;
    end else begin
      memAck <= 1'b0;
    end
    if (rfWe) begin
      rf[rfIdx] <= rfWdata;
      rfWrites <= rfWrites + 1;
    end
  end

  logic isLongQ = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic initState();
    for (int i = 0; i < 1024; i++) begin
      mem[i]  = 8'((i * 37 + 11) ^ (i >> 3));
      emem[i] = mem[i];
    end
    for (int i = 0; i < 16; i++) begin
      rf[i]  = 32'h8000_0000 ^ (i * 32'h0101_1357) ^ (i << 12);
      erf[i] = rf[i];
    end
  endtask

  task automatic waitDone(output int cyc);
    cyc = 0;
    while (!done && cyc < 500) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic run(input bit dir, input logic [1:0] md, input bit lng,
                     input logic [15:0] m, input logic [2:0] br);
    logic [23:0] a, ea[32];
    int n, cyc;
    int step;
    int expCost;
    initState();
    step = lng ? 4 : 2;
    a = (md == 2) ? 24'h200 : 24'h100;
    n = 0;
    for (int p = 0; p < 16; p++) begin
      if (m[p]) begin
        int r;
        r = (md == 2) ? 15 - p : p;
        if (md == 2) a = a - 24'(step);
        ea[n] = a;
        n++;
        if (dir) begin
          if (lng) begin
            emem[a[9:0]] = erf[r][31:24]; emem[a[9:0]+1] = erf[r][23:16];
            emem[a[9:0]+2] = erf[r][15:8]; emem[a[9:0]+3] = erf[r][7:0];
          end else begin
            emem[a[9:0]] = erf[r][15:8]; emem[a[9:0]+1] = erf[r][7:0];
          end
        end else begin
          if (lng) erf[r] = {emem[a[9:0]], emem[a[9:0]+1], emem[a[9:0]+2], emem[a[9:0]+3]};
          else     erf[r] = {{16{emem[a[9:0]][7]}}, emem[a[9:0]], emem[a[9:0]+1]};
        end
        if (md != 2) a = a + 24'(step);
      end
    end
    if (md != 0) erf[8 + br] = {8'h0, a};
    expCost = (dir ? 8 : 12) + n * (lng ? 8 : 4);

    @(negedge clk);
    logCnt = 0;
    isLongQ = lng;
    toMem = dir; mode = md; isLong = lng; mask = m; baseReg = br;
    baseAddr = (md == 2) ? 24'h200 : 24'h100;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    waitDone(cyc);
    check(done, "R11", "done seen", longint'(done), 1);
    check(int'(cost) == expCost, "R6", "cost", cost, expCost);
    @(negedge clk);
    check(!done, "R11", "done one cycle", longint'(done), 0);
    check(logCnt == n, (m == 0) ? "R9" : "R1", "access count", logCnt, n);
    for (int k = 0; k < n && k < logCnt; k++)
      check(logAddr[k] == ea[k], (md == 2) ? "R4" : "R3", "access address",
            logAddr[k], ea[k]);
    for (int r = 0; r < 16; r++)
      check(rf[r] == erf[r], (md == 2) ? "R2" : (r >= 8 ? "R5" : "R7"),
            $sformatf("reg %0d", r), rf[r], erf[r]);
    begin
      int bad = 0, firstBad = 0;
      for (int i = 0; i < 1024; i++)
        if (mem[i] !== emem[i]) begin
          if (bad == 0) firstBad = i;
          bad++;
        end
      check(bad == 0, (md == 2) ? "R2" : "R1", "memory byte mismatches",
            bad, 0);
      if (bad != 0) $display("  first mismatching byte at %h", firstBad);
    end
  endtask

  task automatic badStart(input bit dir, input logic [1:0] md);
    int seen = 0;
    initState();
    logCnt = 0;
    rfWrites = 0;
    @(negedge clk);
    toMem = dir; mode = md; mask = 16'hFFFF; isLong = 1'b1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 6; i++) begin
      if (busy) seen++;
      @(negedge clk);
    end
    check(seen == 0, "R8", "busy after illegal start", seen, 0);
    check(logCnt == 0 && rfWrites == 0, "R8", "accesses after illegal start",
          logCnt + rfWrites, 0);
  endtask

  initial begin
    logic [15:0] masks [6];
    int cyc;
    masks[0] = 16'h0000; masks[1] = 16'hFFFF; masks[2] = 16'h0001;
    masks[3] = 16'h8000; masks[4] = 16'hA5C3; masks[5] = 16'h0F10;
    initState();
    repeat (3) @(negedge clk);
    check(!busy && !done && !memReq && !rfWe, "R11", "reset outputs",
          {busy, done, memReq, rfWe}, 0);
    rstN = 1'b1;
    @(negedge clk);
    for (int mi = 0; mi < 6; mi++)
      for (int lg = 0; lg < 2; lg++) begin
        run(1'b1, 2'd0, lg[0], masks[mi], 3'(mi));
        run(1'b0, 2'd0, lg[0], masks[mi], 3'(mi + 1));
        run(1'b0, 2'd1, lg[0], masks[mi], 3'(mi + 2));
        run(1'b1, 2'd2, lg[0], masks[mi], 3'(mi + 3));
      end
    badStart(1'b0, 2'd2);
    badStart(1'b1, 2'd1);
    badStart(1'b1, 2'd3);
    // start while busy is ignored: second start must not alter the run
    initState();
    logCnt = 0;
    @(negedge clk);
    isLongQ = 1'b1;
    toMem = 1'b0; mode = 2'd1; isLong = 1'b1; mask = 16'h0003; baseReg = 3'd6;
    baseAddr = 24'h100;
    start = 1'b1;
    @(negedge clk);
    mask = 16'hFFFF; baseAddr = 24'h300;
    @(negedge clk);
    start = 1'b0;
    waitDone(cyc);
    check(cost == 8'd28, "R11", "cost with start while busy", cost, 28);
    @(negedge clk);
    check(logCnt == 2, "R11", "accesses with start while busy", logCnt, 2);
    check(rf[14] == 32'h108, "R5", "write-back with start while busy", rf[14], 32'h108);
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    nChk++; nFail++;
    $display("FAIL watchdog expired actual 1 expected 0");
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule